// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM out of power-up into a usable state. After reset it keeps the command bus at NOP until the clock-stable input is seen high. It then counts out a programmable settling wait, still driving NOP. After the wait it issues a precharge to every bank, two auto-refresh commands and a mode-register load. The loaded word is assembled from the configured burst length, burst ordering, CAS latency and write-burst behaviour.

Commands are spaced by the row-precharge, refresh-cycle and mode-register-set times, each given in clock cycles. After the last of these gaps the block raises a sticky done flag. From then on it drives NOP only, so a downstream multiplexer can hand the command pins to the normal access controller. Asserting reset at any point drops the done flag and restarts the whole sequence from the clock-stable wait.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While rstN is low, the command pins show NOP (cmdCsN=0, cmdRasN=1, cmdCasN=1, cmdWeN=1), sdAddr and sdBank are zero and initDone is low. After release, the sequence starts again from the wait for clkStable.
- R2: As long as clkStable has not been sampled high since reset, only NOP is driven and initDone stays low.
- R3: WAIT_CYC = CLK_MHZ * WAIT_US. After the first clock edge that samples clkStable high, NOP is driven for WAIT_CYC+1 cycles, and the precharge appears in the cycle after that.
- R4: The precharge-all command has pins {cmdCsN,cmdRasN,cmdCasN,cmdWeN} = 0010, sdAddr bit 10 = 1, every other address bit 0, and sdBank = 0.
- R5: Auto refresh has pins 0001 with sdAddr and sdBank zero. It is issued twice: the first T_RP cycles after the precharge, the second T_RFC cycles after the first. T_RP, T_RFC and T_MRD are each at least 2.
- R6: The mode-register load has pins 0000 and sdBank zero. It is issued T_RFC cycles after the second refresh. Its sdAddr carries: bits 2:0 the burst-length code (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 the burst ordering (1=interleaved), bits 6:4 the CAS latency, bits 8:7 zero, bit 9 the write-burst mode (1=single writes), and all bits from 10 upward zero.
- R7: initDone rises T_MRD cycles after the mode-register load. It then stays high with NOP on the pins until reset.
- R8: Each command occupies exactly one cycle. Every other cycle carries NOP.
- R9: Once the settling wait has begun, clkStable going low has no effect on the sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clkStable | input | 1 | High once the clock meets its timing limits |
| cfgBurstLen | input | 3 | Burst-length code placed in mode bits 2:0 |
| cfgBurstSeq | input | 1 | Burst ordering, 1 = interleaved |
| cfgCasLat | input | 3 | CAS latency placed in mode bits 6:4 |
| cfgWriteMode | input | 1 | Write-burst mode, 1 = single-location writes |
| cmdCsN | output | 1 | Chip select, active low |
| cmdRasN | output | 1 | Row strobe, active low |
| cmdCasN | output | 1 | Column strobe, active low |
| cmdWeN | output | 1 | Write enable, active low |
| sdAddr | output | ADDR_W | Address bus |
| sdBank | output | BANK_W | Bank select |
| initDone | output | 1 | Sticky flag: initialization complete |

## Verification
The hardest situation to reach from the ports is a reset that lands in the middle of the command phase, after the precharge and one refresh have gone out. The sequencer must then drop initDone at once and replay the full wait and command order with fresh timing. The stimulus counts cycles from the clkStable edge to a point just past the first refresh, pulls reset there, and then expects the whole sequence again. A separate run drops clkStable during the settling wait, to show that the command timing does not move.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Pin order {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdCmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWAIT, ST_PRE, ST_RP, ST_REF1, ST_RFC1,
    ST_REF2, ST_RFC2, ST_LMR, ST_MRD, ST_DONE
  } seqState_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic issueLmr;
    logic markDone;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYC = 10000,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 7,
  parameter int T_MRD    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkStable,
  output seqStrobe_t strobes
);

  localparam int M1    = (WAIT_CYC > T_RP) ? WAIT_CYC : T_RP;
  localparam int M2    = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int MAXC  = (M2 > T_MRD) ? M2 : T_MRD;
  localparam int CNT_W = $clog2(MAXC + 1);

  seqState_e        st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end

  // Gap states last T-1 cycles, so command-to-command spacing is T.
  always_comb begin
    stNext  = st;
    cntNext = (cnt != '0) ? cnt - 1'b1 : cnt;
    unique case (st)
      ST_IDLE:  if (clkStable) begin
                  stNext  = ST_PWAIT;
                  cntNext = CNT_W'(WAIT_CYC - 1);
                end
      ST_PWAIT: if (cnt == '0) stNext = ST_PRE;
      ST_PRE:   begin stNext = ST_RP;   cntNext = CNT_W'(T_RP - 2);  end
      ST_RP:    if (cnt == '0) stNext = ST_REF1;
      ST_REF1:  begin stNext = ST_RFC1; cntNext = CNT_W'(T_RFC - 2); end
      ST_RFC1:  if (cnt == '0) stNext = ST_REF2;
      ST_REF2:  begin stNext = ST_RFC2; cntNext = CNT_W'(T_RFC - 2); end
      ST_RFC2:  if (cnt == '0) stNext = ST_LMR;
      ST_LMR:   begin stNext = ST_MRD;  cntNext = CNT_W'(T_MRD - 2); end
      ST_MRD:   if (cnt == '0) stNext = ST_DONE;
      ST_DONE:  stNext = ST_DONE;
      default:  stNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.issuePre = (st == ST_PRE);
    strobes.issueRef = (st == ST_REF1) || (st == ST_REF2);
    strobes.issueLmr = (st == ST_LMR);
    strobes.markDone = (st == ST_DONE);
  end

endmodule

// File: rtl/sdram_init_dpath.sv
module sdram_init_dpath
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgBurstSeq,
  input  logic [2:0]        cfgCasLat,
  input  logic              cfgWriteMode,
  output sdCmd_e            cmdQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [BANK_W-1:0] bankQ,
  output logic              doneQ
);

  logic [ADDR_W-1:0] modeWord, preWord;

  always_comb begin
    modeWord      = '0;
    modeWord[2:0] = cfgBurstLen;
    modeWord[3]   = cfgBurstSeq;
    modeWord[6:4] = cfgCasLat;
    modeWord[8:7] = 2'b00;
    modeWord[9]   = cfgWriteMode;
    preWord       = '0;
    preWord[10]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      bankQ <= '0;
      doneQ <= 1'b0;
    end else begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      bankQ <= '0;
      if (strobes.issuePre) begin
        cmdQ  <= CMD_PRE;
        addrQ <= preWord;
      end
      if (strobes.issueRef) cmdQ <= CMD_REF;
      if (strobes.issueLmr) begin
        cmdQ  <= CMD_LMR;
        addrQ <= modeWord;
      end
      if (strobes.markDone) doneQ <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int WAIT_US = 100,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 7,
  parameter int T_MRD   = 2,
  parameter int ADDR_W  = 12,
  parameter int BANK_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkStable,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgBurstSeq,
  input  logic [2:0]        cfgCasLat,
  input  logic              cfgWriteMode,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0] sdBank,
  output logic              initDone
);

  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;

  seqStrobe_t strobes;
  sdCmd_e     cmdQ;

  sdram_init_ctrl #(
    .WAIT_CYC(WAIT_CYC), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .clkStable(clkStable), .strobes(strobes)
  );

  sdram_init_dpath #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgBurstLen(cfgBurstLen), .cfgBurstSeq(cfgBurstSeq),
    .cfgCasLat(cfgCasLat), .cfgWriteMode(cfgWriteMode),
    .cmdQ(cmdQ), .addrQ(sdAddr), .bankQ(sdBank), .doneQ(initDone)
  );

  assign {cmdCsN, cmdRasN, cmdCasN, cmdWeN} = cmdQ;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
  import sdram_init_pkg::*;
#(
  parameter int T_RP   = 3,
  parameter int T_RFC  = 7,
  parameter int T_MRD  = 2,
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkStable,
  input logic              cmdCsN,
  input logic              cmdRasN,
  input logic              cmdCasN,
  input logic              cmdWeN,
  input logic [ADDR_W-1:0] sdAddr,
  input logic [BANK_W-1:0] sdBank,
  input logic              initDone
);

  logic [3:0] cmd;
  logic [3:0] lastCmd;
  logic [7:0] gap;
  logic       seenStable;

  always_comb cmd = {cmdCsN, cmdRasN, cmdCasN, cmdWeN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCmd    <= CMD_NOP;
      gap        <= '0;
      seenStable <= 1'b0;
    end else begin
      if (clkStable) seenStable <= 1'b1;
      if (cmd != CMD_NOP) begin
        lastCmd <= cmd;
        gap     <= 8'd1;
      end else if (gap != 8'hFF) begin
        gap <= gap + 8'd1;
      end
    end
  end

  a_r2_nop_before_stable: assert property (@(posedge clk) disable iff (!rstN)
    !seenStable |-> (cmd == CMD_NOP && !initDone));

  a_r4_precharge_all: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_PRE) |-> (sdAddr[10] && $countones(sdAddr) == 1 && sdBank == '0));

  a_r5_first_ref_gap: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_REF && lastCmd == CMD_PRE) |-> (gap == 8'(T_RP)));

  a_r5_second_ref_gap: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_REF && lastCmd == CMD_REF) |-> (gap == 8'(T_RFC)));

  a_r6_load_after_refresh: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_LMR) |-> (lastCmd == CMD_REF && gap == 8'(T_RFC) &&
                          sdAddr[8:7] == 2'b00 && sdBank == '0));

  a_r7_done_timing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (lastCmd == CMD_LMR && gap == 8'(T_MRD)));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (cmd == CMD_NOP));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

endmodule

bind sdram_pwrup_seq sdram_init_chk #(
  .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) chk_i (
  .clk(clk), .rstN(rstN), .clkStable(clkStable),
  .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN),
  .sdAddr(sdAddr), .sdBank(sdBank), .initDone(initDone)
);

// File: tb/sdram_pwrup_seq_tb_top.sv
module sdram_pwrup_seq_tb_top;

  localparam int CLK_MHZ  = 100;
  localparam int WAIT_US  = 2;
  localparam int T_RP     = 3;
  localparam int T_RFC    = 7;
  localparam int T_MRD    = 2;
  localparam int ADDR_W   = 13;
  localparam int BANK_W   = 2;
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;

  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] PRE  = 4'b0010;
  localparam logic [3:0] REF  = 4'b0001;
  localparam logic [3:0] LMR  = 4'b0000;
  localparam logic [3:0] DONE = 4'b1111;  // scoreboard marker for initDone

  logic clk = 1'b0, rstN = 1'b0, clkStable = 1'b0;
  logic [2:0] cfgBurstLen = '0, cfgCasLat = '0;
  logic cfgBurstSeq = 1'b0, cfgWriteMode = 1'b0;
  logic cmdCsN, cmdRasN, cmdCasN, cmdWeN, initDone;
  logic [ADDR_W-1:0] sdAddr;
  logic [BANK_W-1:0] sdBank;

  sdram_pwrup_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .clkStable(clkStable),
    .cfgBurstLen(cfgBurstLen), .cfgBurstSeq(cfgBurstSeq),
    .cfgCasLat(cfgCasLat), .cfgWriteMode(cfgWriteMode),
    .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN),
    .sdAddr(sdAddr), .sdBank(sdBank), .initDone(initDone)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [3:0]        cmd;
    logic [ADDR_W-1:0] addr;
    int                at;
    string             req;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0, fails = 0;
  int  cycNum = 0, startCyc = 0;
  bit  monOn = 0, doneSeen = 0;

  always @(posedge clk) cycNum <= cycNum + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {cmdCsN, cmdRasN, cmdCasN, cmdWeN};
  endfunction

  // Monitor: pop one expected item per command or done edge
  always @(negedge clk) begin
    logic [3:0] c;
    int rel;
    expItem_t e;
    if (monOn) begin
      c   = pins();
      rel = cycNum - startCyc;
      if (c != NOP || (initDone && !doneSeen)) begin
        if (expQ.size() == 0) begin
          check(0, "R8", "unexpected command", c, NOP);
        end else begin
          e = expQ.pop_front();
          check(rel == e.at, e.req, "cycle", rel, e.at);
          if (e.cmd == DONE) begin
            check(initDone && c == NOP, "R7", "done with NOP", {initDone, c}, {1'b1, NOP});
            doneSeen = 1;
          end else begin
            check(c == e.cmd, e.req, "command", c, e.cmd);
            check(sdAddr == e.addr, e.req, "address", sdAddr, e.addr);
            check(sdBank == '0, e.req, "bank", sdBank, 0);
          end
        end
      end else if (doneSeen) begin
        check(initDone && c == NOP, "R7", "done sticky", {initDone, c}, {1'b1, NOP});
      end
    end
  end

  task automatic resetDut();
    monOn = 0;
    @(negedge clk);
    rstN = 1'b0;
    clkStable = 1'b0;
    #1;
    check(pins() == NOP && sdAddr == '0 && sdBank == '0, "R1", "pins in reset",
          {pins(), sdAddr}, {NOP, {ADDR_W{1'b0}}});
    check(!initDone, "R1", "initDone in reset", initDone, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic idleCheck(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(pins() == NOP && !initDone, "R2", "idle without clkStable",
            {initDone, pins()}, {1'b0, NOP});
    end
  endtask

  task automatic startSeq(input logic [2:0] bl, input logic seq,
                          input logic [2:0] cl, input logic wm);
    logic [ADDR_W-1:0] m, p;
    int t;
    cfgBurstLen = bl; cfgBurstSeq = seq; cfgCasLat = cl; cfgWriteMode = wm;
    m = '0; m[2:0] = bl; m[3] = seq; m[6:4] = cl; m[9] = wm;
    p = '0; p[10] = 1'b1;
    expQ.delete();
    doneSeen = 0;
    t = WAIT_CYC + 2;
    expQ.push_back('{PRE, p, t, "R3"});
    t += T_RP;
    expQ.push_back('{REF, '0, t, "R5"});
    t += T_RFC;
    expQ.push_back('{REF, '0, t, "R5"});
    t += T_RFC;
    expQ.push_back('{LMR, m, t, "R6"});
    t += T_MRD;
    expQ.push_back('{DONE, '0, t, "R7"});
    @(negedge clk);
    clkStable = 1'b1;
    startCyc  = cycNum;
    monOn     = 1;
  endtask

  task automatic finishSeq();
    for (int i = 0; i < WAIT_CYC + 200 && !doneSeen; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(expQ.size() == 0 && doneSeen, "R7", "sequence complete", expQ.size(), 0);
  endtask

  initial begin
    // R1/R2: reset state and no activity without clkStable
    resetDut();
    idleCheck(40);

    // R3..R8: 8-beat sequential, CL2, burst writes
    startSeq(3'b011, 1'b0, 3'b010, 1'b0);
    finishSeq();

    // R9: full page, interleaved, CL3, single writes; clkStable drops mid-wait
    resetDut();
    idleCheck(5);
    startSeq(3'b111, 1'b1, 3'b011, 1'b1);
    repeat (20) @(negedge clk);
    clkStable = 1'b0;
    finishSeq();

    // R1: reset just after the first refresh, then full replay
    resetDut();
    startSeq(3'b001, 1'b0, 3'b010, 1'b0);
    repeat (WAIT_CYC + 2 + T_RP + 2) @(negedge clk);
    monOn = 0;
    rstN = 1'b0;
    #1;
    check(!initDone && pins() == NOP, "R1", "mid-sequence reset",
          {initDone, pins()}, {1'b0, NOP});
    repeat (2) @(negedge clk);
    clkStable = 1'b0;
    rstN = 1'b1;
    idleCheck(10);
    startSeq(3'b000, 1'b1, 3'b010, 1'b1);
    finishSeq();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule